// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of a single-rank SDR SDRAM. From reset it holds the bus quiet for the power-up settle time. It then brings the device up in a fixed order: a precharge of every bank, a train of auto-refresh commands, and a mode register load that sets CAS latency, burst length and wrap type. When bring-up is finished it raises `ready`.

In normal operation a free-running interval timer marks each refresh slot. The sequencer issues those refreshes between host operations. A host asks for the bus with `hostReq`, gets `hostGrant`, and hands the bus back with a one-cycle `hostDone`. A due refresh wins over a new grant, but a grant already given is never cut short. If a whole refresh interval goes by with a refresh still owed, the debt grows to two refreshes, issued back to back. The host can also park the device in self-refresh and wake it again. The wake-up keeps the clock enable high for two edges and then waits one full row cycle before the bus is handed back.

All delays are parameters in picoseconds and are turned into clock counts from the clock period. Minimum spacings round up. The refresh interval rounds down.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: Reset and power-up quiet period.
  - While reset is held, and for at least ceil(POWERUP_PS/CLK_PERIOD_PS) cycles after release, the pins carry NOP (csN low, rasN/casN/weN high) with cke high.
  - Throughout that period `ready` and `hostGrant` stay low, even with `hostReq` held high.
- R2: Bring-up order.
  - Bring-up issues exactly one precharge-all (rasN and weN low, casN high, addr[10] high).
  - It then issues INIT_REFS (8) auto-refresh commands (rasN and casN low, weN high, cke high).
  - Only after those does it issue the mode register load (all four strobes low).
- R3: Command spacing.
  - The first refresh follows the precharge by exactly RP_CYC = max(2, ceil(TRP_PS/tCK)) cycles.
  - Each later bring-up refresh and the mode load follow the previous refresh by exactly RC_CYC = max(2, ceil(TRC_PS/tCK)) cycles.
  - No two refreshes are ever closer than RC_CYC.
- R4: Mode word.
  - During the mode load, addr[2:0] holds the burst code (length 1, 2, 4, 8 → 0, 1, 2, 3).
  - addr[3] holds the wrap type (1 = interleaved).
  - addr[6:4] holds the CAS latency (2 or 3).
  - All other address bits and ba are zero. The defaults give addr = 0x032.
- R5: Mode load settle and ready.
  - The two cycles after the mode load carry NOP.
  - `ready` rises exactly two cycles after the mode load appears on the pins.
- R6: Periodic refresh.
  - With the bus idle, the first refresh appears REF_CYC = floor(REF_INT_PS/tCK) cycles after `ready` rises, and then every REF_CYC cycles.
  - The timer runs on its own and does not move when a refresh is serviced late.
- R7: Host grant.
  - With no refresh owed, `hostReq` seen at a clock edge raises `hostGrant` on the following edge.
  - `hostGrant` stays high until `hostDone` is seen, and falls on the edge after that.
- R8: No refresh inside a grant.
  - While `hostGrant` is high the pins carry only NOP.
  - A refresh that fell due during the grant appears on the same edge that `hostGrant` falls.
- R9: Refresh priority. When a refresh is owed in the same cycle that `hostReq` is present, the refresh goes out first. `hostGrant` rises RC_CYC+1 cycles after that refresh.
- R10: Missed refresh window. If a second refresh slot passes while one refresh is still owed, the debt becomes RECOVER_REFS (2). These refreshes are issued back to back, RC_CYC apart, and no further refresh follows them.
- R11: Self-refresh entry.
  - `selfRefEnter` in idle makes the next edge show a refresh command with cke low and `ready` low.
  - Until exit, cke stays low, the pins carry NOP, and `hostReq` gets no grant.
- R12: Self-refresh exit.
  - `selfRefExit` seen at an edge raises cke on the following edge.
  - `ready` returns RC_CYC+2 cycles after cke rises, with NOP throughout.
  - The refresh timer restarts, so the next refresh comes REF_CYC cycles after `ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Host asks for the command bus |
| hostGrant | output | 1 | Host owns the bus; sequencer drives NOP |
| hostDone | input | 1 | One-cycle pulse: host hands the bus back |
| selfRefEnter | input | 1 | Request to put the device into self-refresh |
| selfRefExit | input | 1 | Request to wake the device from self-refresh |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| addr | output | ADDR_W | Address bus (bit 10 = all-bank precharge, mode word on load) |
| ba | output | BANK_W | Bank address, always zero for these commands |
| ready | output | 1 | Bring-up done and device awake |

## Verification
Every output is registered once after the control decision, which gives fixed latencies:
- An input change seen at an edge that makes the sequencer issue a command directly, such as self-refresh entry, shows on the pins at that same edge.
- A change that first moves the state machine, such as a grant, a grant release or a self-refresh exit, shows one edge later.

Refresh slots come from a free-running counter. The bench therefore keeps its own slot schedule from the cycle where `ready` rose, and predicts every refresh, deferred refresh and priority grant by exact cycle number. It drives inputs on falling edges and compares the pins on falling edges at those predicted cycles. Bring-up spacings are measured as exact differences between logged command cycles.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmdKind_t;

  typedef enum logic [1:0] {
    GAP_RP,
    GAP_RC,
    GAP_MRD,
    GAP_SRX
  } gapSel_t;

  // strobes from control to datapath
  typedef struct packed {
    cmdKind_t cmd;
    logic     cke;
    logic     waitLoad;
    gapSel_t  gapSel;
    logic     refRestart;
    logic     refEn;
    logic     ready;
    logic     grant;
  } seqStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [2:0] burstCode(input int len);
    case (len)
      1:       return 3'd0;
      2:       return 3'd1;
      4:       return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

  function automatic logic [31:0] modeWord(input int casLat, input int burstLen, input int interleave);
    logic [31:0] w;
    w = '0;
    w[2:0] = burstCode(burstLen);
    w[3]   = (interleave != 0);
    w[6:4] = 3'(casLat);
    return w;
  endfunction

endpackage

// File: rtl/sdr_seq_dp.sv
module sdr_seq_dp
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int BANK_W  = 2,
  parameter int AP_BIT  = 10,
  parameter int PWR_CYC = 5000,
  parameter int RP_GAP  = 2,
  parameter int RC_GAP  = 4,
  parameter int MRD_GAP = 2,
  parameter int SRX_GAP = 7,
  parameter int REF_CYC = 780,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  output logic              waitDone,
  output logic              refDue,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              cke,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              ready,
  output logic              hostGrant
);

  localparam int WAIT_MAX = maxInt(PWR_CYC, SRX_GAP);
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int REF_W    = $clog2(REF_CYC + 1);

  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] loadVal;
  logic [REF_W-1:0]  refCnt;

  // gap table: a command loaded here lets the next one go exactly GAP cycles later
  always_comb begin
    case (strb.gapSel)
      GAP_RP:  loadVal = WAIT_W'(RP_GAP - 2);
      GAP_RC:  loadVal = WAIT_W'(RC_GAP - 2);
      GAP_MRD: loadVal = WAIT_W'(MRD_GAP - 2);
      default: loadVal = WAIT_W'(SRX_GAP - 2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= WAIT_W'(PWR_CYC - 1);
    end else if (strb.waitLoad) begin
      waitCnt <= loadVal;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign waitDone = (waitCnt == '0);

  // free-running refresh slot timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt <= REF_W'(REF_CYC - 1);
    end else if (strb.refRestart) begin
      refCnt <= REF_W'(REF_CYC - 1);
    end else if (strb.refEn) begin
      if (refCnt == '0) refCnt <= REF_W'(REF_CYC - 1);
      else              refCnt <= refCnt - 1'b1;
    end
  end

  assign refDue = strb.refEn && !strb.refRestart && (refCnt == '0);

  // command decode
  logic [3:0]        pinNext;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    addrNext = '0;
    case (strb.cmd)
      CMD_PRE: begin
        pinNext = 4'b0010;
        addrNext[AP_BIT] = 1'b1;
      end
      CMD_REF: pinNext = 4'b0001;
      CMD_MRS: begin
        pinNext  = 4'b0000;
        addrNext = MODE_WORD;
      end
      default: pinNext = 4'b0111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {csN, rasN, casN, weN} <= 4'b0111;
      cke       <= 1'b1;
      addr      <= '0;
      ba        <= '0;
      ready     <= 1'b0;
      hostGrant <= 1'b0;
    end else begin
      {csN, rasN, casN, weN} <= pinNext;
      cke       <= strb.cke;
      addr      <= addrNext;
      ba        <= '0;
      ready     <= strb.ready;
      hostGrant <= strb.grant;
    end
  end

endmodule

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
  import sdr_seq_pkg::*;
#(
  parameter int INIT_REFS    = 8,
  parameter int RECOVER_REFS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReq,
  input  logic       hostDone,
  input  logic       srEnter,
  input  logic       srExit,
  input  logic       waitDone,
  input  logic       refDue,
  output seqStrobe_t strb
);

  localparam int IREF_W = $clog2(INIT_REFS + 1);
  localparam int PEND_W = $clog2(RECOVER_REFS + 1);

  typedef enum logic [3:0] {
    S_POWER, S_PRE, S_PRE_W, S_IREF, S_IREF_W, S_MRS, S_MRS_W,
    S_IDLE, S_HOST, S_REF_W, S_SREF, S_SRX_W
  } state_t;

  state_t            state, nextState;
  logic [IREF_W-1:0] irefCnt;
  logic [PEND_W-1:0] pendCnt, pendAfter;
  logic              issueRef;
  logic              irefInc;

  always_comb begin
    strb            = '0;
    strb.cmd        = CMD_NOP;
    strb.cke        = 1'b1;
    strb.gapSel     = GAP_RC;
    nextState       = state;
    issueRef        = 1'b0;
    irefInc         = 1'b0;
    case (state)
      S_POWER: if (waitDone) nextState = S_PRE;
      S_PRE: begin
        strb.cmd      = CMD_PRE;
        strb.waitLoad = 1'b1;
        strb.gapSel   = GAP_RP;
        nextState     = S_PRE_W;
      end
      S_PRE_W: if (waitDone) nextState = S_IREF;
      S_IREF: begin
        strb.cmd      = CMD_REF;
        strb.waitLoad = 1'b1;
        irefInc       = 1'b1;
        nextState     = S_IREF_W;
      end
      S_IREF_W: if (waitDone) nextState = (irefCnt == IREF_W'(INIT_REFS)) ? S_MRS : S_IREF;
      S_MRS: begin
        strb.cmd      = CMD_MRS;
        strb.waitLoad = 1'b1;
        strb.gapSel   = GAP_MRD;
        nextState     = S_MRS_W;
      end
      S_MRS_W: if (waitDone) begin
        strb.refRestart = 1'b1;
        nextState       = S_IDLE;
      end
      S_IDLE: begin
        strb.ready = 1'b1;
        strb.refEn = 1'b1;
        if (pendCnt != '0) begin
          strb.cmd      = CMD_REF;
          strb.waitLoad = 1'b1;
          issueRef      = 1'b1;
          nextState     = S_REF_W;
        end else if (srEnter) begin
          strb.cmd   = CMD_REF;
          strb.cke   = 1'b0;
          strb.ready = 1'b0;
          nextState  = S_SREF;
        end else if (hostReq) begin
          nextState = S_HOST;
        end
      end
      S_HOST: begin
        strb.ready = 1'b1;
        strb.refEn = 1'b1;
        strb.grant = 1'b1;
        if (hostDone) nextState = S_IDLE;
      end
      S_REF_W: begin
        strb.ready = 1'b1;
        strb.refEn = 1'b1;
        if (waitDone) nextState = S_IDLE;
      end
      S_SREF: begin
        strb.cke = 1'b0;
        if (srExit) begin
          strb.waitLoad = 1'b1;
          strb.gapSel   = GAP_SRX;
          nextState     = S_SRX_W;
        end
      end
      S_SRX_W: if (waitDone) begin
        strb.refRestart = 1'b1;
        nextState       = S_IDLE;
      end
      default: nextState = S_POWER;
    endcase
  end

  // owed refreshes: a slot passing while one is still owed raises the debt to the recovery count
  always_comb begin
    pendAfter = pendCnt - PEND_W'(issueRef);
    if (refDue) pendAfter = (pendAfter == '0) ? PEND_W'(1) : PEND_W'(RECOVER_REFS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_POWER;
      irefCnt <= '0;
      pendCnt <= '0;
    end else begin
      state   <= nextState;
      if (irefInc) irefCnt <= irefCnt + 1'b1;
      pendCnt <= strb.refRestart ? '0 : pendAfter;
    end
  end

endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 20000,
  parameter int POWERUP_PS    = 100000000,
  parameter int TRP_PS        = 20000,
  parameter int TRC_PS        = 70000,
  parameter int REF_INT_PS    = 15600000,
  parameter int MRD_CLK       = 2,
  parameter int INIT_REFS     = 8,
  parameter int RECOVER_REFS  = 2,
  parameter int CAS_LAT       = 3,
  parameter int BURST_LEN     = 4,
  parameter int INTERLEAVE    = 0,
  parameter int ADDR_W        = 12,
  parameter int BANK_W        = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  output logic              hostGrant,
  input  logic              hostDone,
  input  logic              selfRefEnter,
  input  logic              selfRefExit,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              cke,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              ready
);

  localparam int PWR_CYC = maxInt(2, ceilDiv(POWERUP_PS, CLK_PERIOD_PS));
  localparam int RP_CYC  = maxInt(2, ceilDiv(TRP_PS, CLK_PERIOD_PS));
  localparam int RC_CYC  = maxInt(2, ceilDiv(TRC_PS, CLK_PERIOD_PS));
  localparam int MRD_GAP = maxInt(2, MRD_CLK);
  localparam int SRX_GAP = RC_CYC + 3;
  localparam int REF_CYC = REF_INT_PS / CLK_PERIOD_PS;
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(modeWord(CAS_LAT, BURST_LEN, INTERLEAVE));

  seqStrobe_t strb;
  logic       waitDone;
  logic       refDue;

  sdr_seq_ctrl #(
    .INIT_REFS   (INIT_REFS),
    .RECOVER_REFS(RECOVER_REFS)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostReq (hostReq),
    .hostDone(hostDone),
    .srEnter (selfRefEnter),
    .srExit  (selfRefExit),
    .waitDone(waitDone),
    .refDue  (refDue),
    .strb    (strb)
  );

  sdr_seq_dp #(
    .ADDR_W   (ADDR_W),
    .BANK_W   (BANK_W),
    .AP_BIT   (10),
    .PWR_CYC  (PWR_CYC),
    .RP_GAP   (RP_CYC),
    .RC_GAP   (RC_CYC),
    .MRD_GAP  (MRD_GAP),
    .SRX_GAP  (SRX_GAP),
    .REF_CYC  (REF_CYC),
    .MODE_WORD(MODE_WORD)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .waitDone (waitDone),
    .refDue   (refDue),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .cke      (cke),
    .addr     (addr),
    .ba       (ba),
    .ready    (ready),
    .hostGrant(hostGrant)
  );

endmodule

// File: rtl/sdr_seq_chk.sv
module sdr_seq_chk #(
  parameter int RC_CYC    = 4,
  parameter int INIT_REFS = 8
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic cke,
  input logic hostGrant,
  input logic ready
);

  logic isNop, isPre, isRef, isMrs;
  assign isNop = !csN && rasN && casN && weN;
  assign isPre = !csN && !rasN && casN && !weN;
  assign isRef = !csN && !rasN && !casN && weN;
  assign isMrs = !csN && !rasN && !casN && !weN;

  logic        preSeen;
  logic [7:0]  refSincePre;
  logic [15:0] sinceRef;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preSeen     <= 1'b0;
      refSincePre <= '0;
      sinceRef    <= '1;
    end else begin
      if (isPre) begin
        preSeen     <= 1'b1;
        refSincePre <= '0;
      end else if (isRef && refSincePre != '1) begin
        refSincePre <= refSincePre + 1'b1;
      end
      if (isRef)               sinceRef <= 16'd1;
      else if (sinceRef != '1) sinceRef <= sinceRef + 1'b1;
    end
  end

  // R2
  mrs_after_init_refs_chk: assert property (@(posedge clk) disable iff (!rstN)
    isMrs |-> (preSeen && refSincePre >= 8'(INIT_REFS)));

  // R3
  ref_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRef |-> (sinceRef >= 16'(RC_CYC)));

  // R5
  mrs_settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    isMrs |=> isNop);

  // R5
  mrs_settle2_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(isMrs) |=> isNop);

  // R7
  grant_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostGrant |-> ready);

  // R8
  grant_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostGrant |-> isNop);

  // R11
  cke_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> (isRef && !ready));

  // R11
  sref_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cke && !$fell(cke)) |-> (isNop && !ready && !hostGrant));

  // R12
  sref_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (!ready && isNop));

endmodule

bind sdram_init_refresh_seq sdr_seq_chk #(
  .RC_CYC   (RC_CYC),
  .INIT_REFS(INIT_REFS)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .cke      (cke),
  .hostGrant(hostGrant),
  .ready    (ready)
);

// File: tb/sim_sdram_init_refresh_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_refresh_seq;

  localparam int PWR  = 5000;
  localparam int RP   = 2;
  localparam int RC   = 4;
  localparam int REFC = 780;
  localparam int MODE = 12'h032;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostReq = 1'b0, hostDone = 1'b0, selfRefEnter = 1'b0, selfRefExit = 1'b0;
  logic hostGrant, csN, rasN, casN, weN, cke, ready;
  logic [11:0] addr;
  logic [1:0]  ba;

  int cyc = 0;
  int nChecks = 0;
  int nErr = 0;
  int nextDue = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_init_refresh_seq u0 (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostGrant(hostGrant), .hostDone(hostDone),
    .selfRefEnter(selfRefEnter), .selfRefExit(selfRefExit), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .cke(cke), .addr(addr), .ba(ba), .ready(ready)
  );

  // 0 nop, 1 precharge, 2 refresh, 3 mode load, 4 other
  function automatic int cmdCode();
    case ({csN, rasN, casN, weN})
      4'b0111: return 0;
      4'b0010: return 1;
      4'b0001: return 2;
      4'b0000: return 3;
      default: return 4;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tickTo(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic nextCmd(output int at, output int code);
    do @(negedge clk); while (cmdCode() == 0);
    at = cyc;
    code = cmdCode();
  endtask

  // count cycles that are not quiet NOP with the given cke/grant levels
  task automatic quiet(input int n, input logic expCke, input logic expGrant, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cmdCode() != 0 || cke !== expCke || hostGrant !== expGrant) bad++;
    end
  endtask

  task automatic testReset();
    int at, code, bad;
    hostReq = 1'b1;
    repeat (5) @(negedge clk);
    check(cmdCode() == 0, "R1 nop in reset", cmdCode(), 0);
    check(cke == 1'b1 && ready == 1'b0 && hostGrant == 1'b0, "R1 reset levels",
          {cke, ready, hostGrant}, 3'b100);
    rstN = 1'b1;
    at = cyc;
    bad = 0;
    do begin
      @(negedge clk);
      if (hostGrant || ready || !cke) bad++;
    end while (cmdCode() == 0);
    check(bad == 0, "R1 quiet levels", bad, 0);
    check(cyc - at - 1 >= PWR, "R1 power-up nop count", cyc - at - 1, PWR);
    code = cmdCode();
    check(code == 1 && addr[10] == 1'b1, "R2 first command precharge-all", code, 1);
  endtask

  task automatic testInit();
    int prev, at, code, bad;
    prev = cyc;
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      nextCmd(at, code);
      check(code == 2 && cke, "R2 init refresh", code, 2);
      check(at - prev == ((i == 0) ? RP : RC), "R3 init gap", at - prev, (i == 0) ? RP : RC);
      if (hostGrant) bad++;
      prev = at;
    end
    nextCmd(at, code);
    hostReq = 1'b0;
    check(code == 3, "R2 mode load after refreshes", code, 3);
    check(at - prev == RC, "R3 mode load gap", at - prev, RC);
    check(int'(addr) == MODE && ba == 2'b00, "R4 mode word", int'(addr), MODE);
    check(bad == 0 && !hostGrant, "R1 no grant in bring-up", bad, 0);
    @(negedge clk);
    check(cmdCode() == 0 && !ready, "R5 settle cycle one", ready, 0);
    @(negedge clk);
    check(cmdCode() == 0 && ready, "R5 ready after settle", ready, 1);
    nextDue = cyc + REFC;
  endtask

  task automatic testPeriodic();
    int at, code;
    nextCmd(at, code);
    check(code == 2 && at == nextDue, "R6 first periodic refresh", at, nextDue);
    nextDue += REFC;
    nextCmd(at, code);
    check(code == 2 && at == nextDue, "R6 second periodic refresh", at, nextDue);
    nextDue += REFC;
  endtask

  task automatic testGrant();
    int c, bad;
    tickTo(cyc + 10);
    c = cyc;
    hostReq = 1'b1;
    @(negedge clk);
    check(!hostGrant, "R7 grant not yet", hostGrant, 0);
    @(negedge clk);
    check(hostGrant, "R7 grant rises", hostGrant, 1);
    hostReq = 1'b0;
    quiet(40, 1'b1, 1'b1, bad);
    check(bad == 0, "R8 quiet while granted", bad, 0);
    hostDone = 1'b1;
    @(negedge clk);
    hostDone = 1'b0;
    check(hostGrant, "R7 grant held one edge", hostGrant, 1);
    @(negedge clk);
    check(!hostGrant && cyc - c < 60, "R7 grant released", hostGrant, 0);
  endtask

  task automatic testDefer();
    int at, code, bad;
    nextCmd(at, code);
    check(code == 2 && at == nextDue, "R6 refresh on slot", at, nextDue);
    nextDue += REFC;
    tickTo(cyc + 10);
    hostReq = 1'b1;
    repeat (2) @(negedge clk);
    hostReq = 1'b0;
    quiet(nextDue + 30 - cyc, 1'b1, 1'b1, bad);
    check(bad == 0, "R8 refresh held off in grant", bad, 0);
    hostDone = 1'b1;
    @(negedge clk);
    hostDone = 1'b0;
    @(negedge clk);
    check(!hostGrant && cmdCode() == 2, "R8 deferred refresh at release", cmdCode(), 2);
    quiet(20, 1'b1, 1'b0, bad);
    check(bad == 0, "R8 only one deferred refresh", bad, 0);
    nextDue += REFC;
  endtask

  task automatic testPriority();
    int bad;
    tickTo(nextDue - 1);
    hostReq = 1'b1;
    @(negedge clk);
    check(cmdCode() == 2 && cyc == nextDue, "R9 refresh first", cmdCode(), 2);
    bad = 0;
    while (cyc < nextDue + RC) begin
      @(negedge clk);
      if (hostGrant) bad++;
    end
    check(bad == 0, "R9 no grant before refresh gap", bad, 0);
    @(negedge clk);
    check(hostGrant, "R9 grant after refresh", hostGrant, 1);
    hostReq = 1'b0;
    hostDone = 1'b1;
    @(negedge clk);
    hostDone = 1'b0;
    @(negedge clk);
    nextDue += REFC;
  endtask

  task automatic testMissed();
    int at, code, first, bad;
    hostReq = 1'b1;
    repeat (2) @(negedge clk);
    hostReq = 1'b0;
    check(hostGrant, "R7 grant for long hold", hostGrant, 1);
    quiet(nextDue + REFC + 30 - cyc, 1'b1, 1'b1, bad);
    check(bad == 0, "R8 quiet across two slots", bad, 0);
    hostDone = 1'b1;
    @(negedge clk);
    hostDone = 1'b0;
    @(negedge clk);
    first = cyc;
    check(cmdCode() == 2 && !hostGrant, "R10 first recovery refresh", cmdCode(), 2);
    nextCmd(at, code);
    check(code == 2 && at - first == RC, "R10 second recovery refresh gap", at - first, RC);
    quiet(30, 1'b1, 1'b0, bad);
    check(bad == 0, "R10 no third refresh", bad, 0);
    nextDue += 2 * REFC;
  endtask

  task automatic testSelfRefresh();
    int e, bad, at, code, rdyAt;
    tickTo(cyc + 10);
    selfRefEnter = 1'b1;
    @(negedge clk);
    selfRefEnter = 1'b0;
    check(cmdCode() == 2 && !cke && !ready, "R11 self-refresh entry", {cmdCode(), cke, ready}, 8);
    hostReq = 1'b1;
    bad = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (cmdCode() != 0 || cke || ready || hostGrant) bad++;
    end
    check(bad == 0, "R11 parked quiet", bad, 0);
    hostReq = 1'b0;
    e = cyc;
    selfRefExit = 1'b1;
    @(negedge clk);
    selfRefExit = 1'b0;
    check(!cke, "R12 cke still low", cke, 0);
    @(negedge clk);
    check(cke && cyc == e + 2, "R12 cke rises", cke, 1);
    bad = 0;
    while (cyc < e + RC + 3) begin
      @(negedge clk);
      if (ready || cmdCode() != 0 || !cke) bad++;
    end
    check(bad == 0, "R12 recovery wait", bad, 0);
    @(negedge clk);
    check(ready && cyc == e + RC + 4, "R12 ready returns", ready, 1);
    rdyAt = cyc;
    nextCmd(at, code);
    check(code == 2 && at == rdyAt + REFC, "R12 refresh timer restarted", at, rdyAt + REFC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    testReset();
    testInit();
    testPeriodic();
    testGrant();
    testDefer();
    testPriority();
    testMissed();
    testSelfRefresh();
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

endmodule